// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Suspend

This block drives timed word programming and whole-block erasure on a small behavioural flash array and lets a running operation be paused and later continued. A requester presents one command per cycle with a block index, a word index and data: read, program, erase, suspend, resume or clear-status. Program and erase each take a configurable number of clock cycles. Completion is marked by a one-cycle `done` pulse, and the `ready` output returns high.

Suspending an erase lets the requester read, or program single words, in any block other than the one being erased. Suspending a program allows only reads from other blocks. A resume continues the operation from the cycle count that remained, so its total busy time is the same as an uninterrupted run. Commands that break these rules are dropped and raise a sticky sequence error. Program or erase aimed at a block marked in the external lock mask is dropped and raises a sticky protect error. The array starts erased, with every bit at one. A program can only clear bits.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, `ready`=1, `suspended`=0, `done`=0, `seq_err`=0, `prot_err`=0, and every word of every block reads as all ones. Command codes on `req_op`: 0 none, 1 read, 2 program, 3 erase, 4 suspend, 5 resume, 6 clear-status.
- R2: A program of an unlocked word from idle holds `ready` low for exactly PROG_CYCLES cycles. Afterwards the word reads as its old value AND the program data.
- R3: An erase of an unlocked block holds `ready` low for exactly ERASE_CYCLES cycles. Afterwards every word of that block reads all ones, and other blocks are unchanged.
- R4: A suspend during an erase leaves `ready`=1 and `suspended`=1. While suspended, reads and programs to other blocks complete normally, and `suspended` stays 1 through such a program.
- R5: While a program is suspended, reads of other blocks complete. A program or erase request is dropped, sets `seq_err`, and leaves the array unchanged.
- R6: While suspended, a read or program aimed at the suspended operation's block is dropped: no `rd_valid`, and `seq_err` is set.
- R7: After resume, the busy cycles of the interrupted operation (the suspend cycle included, nested programs excluded) total PROG_CYCLES or ERASE_CYCLES. The operation's result is the same as an uninterrupted run.
- R8: A program or erase to a block whose `lock_mask` bit is 1 sets `prot_err`, leaves `ready` high and changes no data.
- R9: While `ready`=0, any command other than suspend or clear is dropped and sets `seq_err`. A suspend or resume while idle is also dropped and sets `seq_err`.
- R10: A suspend that arrives in the final busy cycle does not stop the operation. The operation completes, `done` pulses, `suspended` stays 0 and `seq_err` is set.
- R11: A clear-status command resets `seq_err` and `prot_err` on the next cycle.
- R12: `done` is a single-cycle pulse after each program or erase completes, nested programs included, and `ready` is 1 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present this cycle |
| req_op | input | 3 | Command code (see R1) |
| req_block | input | $clog2(NUM_BLOCKS) | Target block |
| req_word | input | $clog2(WORDS_PER_BLOCK) | Target word within block |
| req_data | input | DATA_W | Program data |
| lock_mask | input | NUM_BLOCKS | Per-block protection, 1 = locked |
| ready | output | 1 | Accepting new operations (idle or suspended) |
| suspended | output | 1 | An operation is suspended |
| done | output | 1 | Program/erase completion pulse |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data |
| seq_err | output | 1 | Sticky sequence error |
| prot_err | output | 1 | Sticky protect error |

## Verification
A suspend request and the completion of the running operation can fall in the same cycle. The bench provokes this by issuing the suspend exactly PROG_CYCLES-1 cycles after a program is accepted. It then checks that completion wins: `done` pulses, `suspended` stays low, `seq_err` rises and the word holds its programmed value. A second collision comes from a suspend issued mid-run. That suspend cycle still counts toward the run, and the bench sums the busy cycles on both sides of the suspension against the uninterrupted duration.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_READ   = 3'd1,
    OP_PROG   = 3'd2,
    OP_ERASE  = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5,
    OP_CLEAR  = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_PSUSP = 3'd3,
    ST_ESUSP = 3'd4,
    ST_NPROG = 3'd5
  } state_e;

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             save,
  input  logic             restore,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] sav_q, sav_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = load_val;
    else if (restore) cnt_d = sav_q;
    else if (step)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    sav_d = sav_q;
    if (save) sav_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sav_q <= '0;
    end else begin
      if (load || restore || step) cnt_q <= cnt_d;
      if (save)                    sav_q <= sav_d;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fseq_array.sv
module fseq_array #(
  parameter int NUM_BLOCKS      = 8,
  parameter int WORDS_PER_BLOCK = 16,
  parameter int DATA_W          = 16,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int WORD_W = $clog2(WORDS_PER_BLOCK),
  localparam int ADDR_W = BLK_W + WORD_W,
  localparam int NWORDS = NUM_BLOCKS * WORDS_PER_BLOCK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_prog,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              wr_erase,
  input  logic [BLK_W-1:0]  erase_blk,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cell_q [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    localparam logic [BLK_W-1:0]  MY_BLK  = BLK_W'(i / WORDS_PER_BLOCK);
    logic              hit_erase, hit_prog;
    logic [DATA_W-1:0] word_d;

    assign hit_erase = wr_erase && (erase_blk == MY_BLK);
    assign hit_prog  = wr_prog && (prog_addr == MY_ADDR);

    always_comb begin
      word_d = cell_q[i];
      if (hit_erase)     word_d = '1;
      else if (hit_prog) word_d = cell_q[i] & prog_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cell_q[i] <= '1;
      else if (hit_erase || hit_prog) cell_q[i] <= word_d;
    end
  end

  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= cell_q[rd_addr];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/fseq_guard.sv
module fseq_guard #(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  flash_seq_pkg::state_e state,
  input  flash_seq_pkg::op_e    op,
  input  logic [BLK_W-1:0]      blk,
  input  logic [BLK_W-1:0]      susp_blk,
  input  logic [NUM_BLOCKS-1:0] lock_mask,
  input  logic                  last,
  output logic                  go_read,
  output logic                  go_prog,
  output logic                  go_erase,
  output logic                  go_susp,
  output logic                  go_resume,
  output logic                  go_clear,
  output logic                  seq_fault,
  output logic                  prot_fault
);
  import flash_seq_pkg::*;

  logic locked, same_blk;
  assign locked   = lock_mask[blk];
  assign same_blk = (blk == susp_blk);

  always_comb begin
    go_read    = 1'b0;
    go_prog    = 1'b0;
    go_erase   = 1'b0;
    go_susp    = 1'b0;
    go_resume  = 1'b0;
    go_clear   = (op == OP_CLEAR);
    seq_fault  = 1'b0;
    prot_fault = 1'b0;
    if (op != OP_NOP && op != OP_CLEAR) begin
      unique case (state)
        ST_IDLE: begin
          case (op)
            OP_READ:  go_read = 1'b1;
            OP_PROG:  begin prot_fault = locked; go_prog  = !locked; end
            OP_ERASE: begin prot_fault = locked; go_erase = !locked; end
            default:  seq_fault = 1'b1;
          endcase
        end
        ST_PROG, ST_ERASE: begin
          if (op == OP_SUSP && !last) go_susp   = 1'b1;
          else                        seq_fault = 1'b1;
        end
        ST_PSUSP: begin
          case (op)
            OP_READ:   begin seq_fault = same_blk; go_read = !same_blk; end
            OP_RESUME: go_resume = 1'b1;
            default:   seq_fault = 1'b1;
          endcase
        end
        ST_ESUSP: begin
          case (op)
            OP_READ:   begin seq_fault = same_blk; go_read = !same_blk; end
            OP_PROG: begin
              seq_fault  = same_blk;
              prot_fault = !same_blk && locked;
              go_prog    = !same_blk && !locked;
            end
            OP_RESUME: go_resume = 1'b1;
            default:   seq_fault = 1'b1;
          endcase
        end
        default: seq_fault = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer #(
  parameter int NUM_BLOCKS      = 8,
  parameter int WORDS_PER_BLOCK = 16,
  parameter int DATA_W          = 16,
  parameter int PROG_CYCLES     = 20,
  parameter int ERASE_CYCLES    = 200
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic [2:0]                         req_op,
  input  logic [$clog2(NUM_BLOCKS)-1:0]      req_block,
  input  logic [$clog2(WORDS_PER_BLOCK)-1:0] req_word,
  input  logic [DATA_W-1:0]                  req_data,
  input  logic [NUM_BLOCKS-1:0]              lock_mask,
  output logic                               ready,
  output logic                               suspended,
  output logic                               done,
  output logic                               rd_valid,
  output logic [DATA_W-1:0]                  rd_data,
  output logic                               seq_err,
  output logic                               prot_err
);
  import flash_seq_pkg::*;

  localparam int BLK_W   = $clog2(NUM_BLOCKS);
  localparam int WORD_W  = $clog2(WORDS_PER_BLOCK);
  localparam int ADDR_W  = BLK_W + WORD_W;
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic [DATA_W-1:0] cur_data_q, cur_data_d;
  logic [BLK_W-1:0]  erase_blk_q, erase_blk_d;
  logic              done_q, done_d;
  logic              rdv_q;
  logic              seq_q, seq_d, prot_q, prot_d;

  op_e               op_in;
  logic [BLK_W-1:0]  susp_blk;
  logic [ADDR_W-1:0] req_addr;
  logic              go_read, go_prog, go_erase, go_susp, go_resume, go_clear;
  logic              seq_fault, prot_fault;
  logic              t_load, t_step, t_save, t_restore, t_last;
  logic [CNT_W-1:0]  t_val;
  logic              wr_prog, wr_erase;

  assign op_in    = req_valid ? op_e'(req_op) : OP_NOP;
  assign req_addr = {req_block, req_word};
  assign susp_blk = (state_q == ST_PSUSP) ? cur_addr_q[ADDR_W-1 -: BLK_W] : erase_blk_q;

  fseq_guard #(.NUM_BLOCKS(NUM_BLOCKS)) u_guard (
    .state(state_q), .op(op_in), .blk(req_block), .susp_blk(susp_blk),
    .lock_mask(lock_mask), .last(t_last),
    .go_read(go_read), .go_prog(go_prog), .go_erase(go_erase),
    .go_susp(go_susp), .go_resume(go_resume), .go_clear(go_clear),
    .seq_fault(seq_fault), .prot_fault(prot_fault)
  );

  fseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .step(t_step), .save(t_save), .restore(t_restore), .last(t_last)
  );

  fseq_array #(
    .NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK), .DATA_W(DATA_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_en(go_read), .rd_addr(req_addr),
    .wr_prog(wr_prog), .prog_addr(cur_addr_q), .prog_data(cur_data_q),
    .wr_erase(wr_erase), .erase_blk(erase_blk_q),
    .rd_data(rd_data)
  );

  // next-state process
  always_comb begin
    state_d     = state_q;
    cur_addr_d  = cur_addr_q;
    cur_data_d  = cur_data_q;
    erase_blk_d = erase_blk_q;
    t_load      = 1'b0;
    t_val       = CNT_W'(PROG_CYCLES);
    t_step      = 1'b0;
    t_save      = 1'b0;
    t_restore   = 1'b0;
    wr_prog     = 1'b0;
    wr_erase    = 1'b0;
    done_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_prog) begin
          state_d    = ST_PROG;
          cur_addr_d = req_addr;
          cur_data_d = req_data;
          t_load     = 1'b1;
        end else if (go_erase) begin
          state_d     = ST_ERASE;
          erase_blk_d = req_block;
          t_load      = 1'b1;
          t_val       = CNT_W'(ERASE_CYCLES);
        end
      end
      ST_PROG, ST_ERASE: begin
        if (go_susp) begin
          state_d = (state_q == ST_PROG) ? ST_PSUSP : ST_ESUSP;
          t_step  = 1'b1;
          t_save  = 1'b1;
        end else if (t_last) begin
          state_d  = ST_IDLE;
          wr_prog  = (state_q == ST_PROG);
          wr_erase = (state_q == ST_ERASE);
          done_d   = 1'b1;
        end else begin
          t_step = 1'b1;
        end
      end
      ST_NPROG: begin
        if (t_last) begin
          state_d = ST_ESUSP;
          wr_prog = 1'b1;
          done_d  = 1'b1;
        end else begin
          t_step = 1'b1;
        end
      end
      ST_PSUSP: begin
        if (go_resume) begin
          state_d   = ST_PROG;
          t_restore = 1'b1;
        end
      end
      ST_ESUSP: begin
        if (go_resume) begin
          state_d   = ST_ERASE;
          t_restore = 1'b1;
        end else if (go_prog) begin
          state_d    = ST_NPROG;
          cur_addr_d = req_addr;
          cur_data_d = req_data;
          t_load     = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    seq_d  = go_clear ? 1'b0 : (seq_q  | seq_fault);
    prot_d = go_clear ? 1'b0 : (prot_q | prot_fault);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_addr_q  <= '0;
      cur_data_q  <= '0;
      erase_blk_q <= '0;
      done_q      <= 1'b0;
      rdv_q       <= 1'b0;
      seq_q       <= 1'b0;
      prot_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (t_load)   cur_addr_q  <= cur_addr_d;
      if (t_load)   cur_data_q  <= cur_data_d;
      if (go_erase) erase_blk_q <= erase_blk_d;
      done_q <= done_d;
      rdv_q  <= go_read;
      seq_q  <= seq_d;
      prot_q <= prot_d;
    end
  end

  assign ready     = (state_q == ST_IDLE) || (state_q == ST_PSUSP) || (state_q == ST_ESUSP);
  assign suspended = (state_q == ST_PSUSP) || (state_q == ST_ESUSP) || (state_q == ST_NPROG);
  assign done      = done_q;
  assign rd_valid  = rdv_q;
  assign seq_err   = seq_q;
  assign prot_err  = prot_q;

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int NUM_BLOCKS = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic [2:0]                    req_op,
  input logic [$clog2(NUM_BLOCKS)-1:0] req_block,
  input logic [NUM_BLOCKS-1:0]         lock_mask,
  input logic                          ready,
  input logic                          suspended,
  input logic                          done,
  input logic                          rd_valid,
  input logic                          seq_err,
  input logic                          prot_err,
  input flash_seq_pkg::state_e         state_q
);
  import flash_seq_pkg::*;

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  a_r9_busy_prog_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && req_valid && req_op == OP_PROG) |=> seq_err);

  a_r11_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_CLEAR) |=> (!seq_err && !prot_err));

  a_r8_locked_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !suspended && req_valid && req_op == OP_ERASE && lock_mask[req_block])
    |=> (prot_err && ready && !suspended));

  a_r5_psusp_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PSUSP && req_valid && req_op == OP_PROG)
    |=> (state_q == ST_PSUSP && seq_err));

  a_r6_read_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && req_op == OP_READ));

  a_r4_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && state_q != ST_NPROG) |-> ready);

endmodule

bind flash_op_sequencer fseq_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_fseq_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_block(req_block), .lock_mask(lock_mask), .ready(ready),
  .suspended(suspended), .done(done), .rd_valid(rd_valid),
  .seq_err(seq_err), .prot_err(prot_err), .state_q(state_q)
);

// File: tb/tb_flash_op_sequencer.sv
module tb_flash_op_sequencer;

  localparam int NB = 4;
  localparam int WB = 4;
  localparam int DW = 16;
  localparam int PC = 3;
  localparam int EC = 6;
  localparam int NW = NB * WB;

  localparam logic [2:0] C_READ = 3'd1, C_PROG = 3'd2, C_ERASE = 3'd3,
                         C_SUSP = 3'd4, C_RES = 3'd5, C_CLR = 3'd6;

  logic clk, rst_n, req_valid;
  logic [2:0] req_op;
  logic [1:0] req_block, req_word;
  logic [DW-1:0] req_data;
  logic [NB-1:0] lock_mask;
  logic ready, suspended, done, rd_valid, seq_err, prot_err;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  logic [DW-1:0] model [NW];

  flash_op_sequencer #(
    .NUM_BLOCKS(NB), .WORDS_PER_BLOCK(WB), .DATA_W(DW),
    .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_block(req_block), .req_word(req_word), .req_data(req_data),
    .lock_mask(lock_mask), .ready(ready), .suspended(suspended), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .seq_err(seq_err), .prot_err(prot_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && !ready) busy_cnt <= busy_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int b, input int w, input logic [DW-1:0] d);
    req_valid = 1'b1; req_op = op; req_block = 2'(b); req_word = 2'(w); req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic rd_chk(input int b, input int w, input string req);
    issue(C_READ, b, w, '0);
    chk(rd_valid && rd_data == model[b*WB+w], req, int'(rd_data), int'(model[b*WB+w]));
  endtask

  task automatic clear_flags(input string req);
    issue(C_CLR, 0, 0, '0);
    chk(!seq_err && !prot_err, req, {seq_err, prot_err}, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0, c1, c2, c3;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_block = '0; req_word = '0;
    req_data = '0; lock_mask = 4'b1000;
    for (int i = 0; i < NW; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and erased array
    chk(ready && !suspended && !done && !seq_err && !prot_err, "R1 status", 
        {ready, suspended, done, seq_err, prot_err}, 5'b10000);
    for (int i = 0; i < NW; i++) rd_chk(i / WB, i % WB, "R1 erased");

    // R2 program sweep, two patterns, busy length and done pulse (R12)
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 3 * WB; i++) begin
        logic [DW-1:0] d;
        d = (pass == 0) ? ~(16'h1 << i) : (16'hF0F0 ^ 16'(i * 16'h0111));
        model[i] = model[i] & d;
        c0 = busy_cnt;
        issue(C_PROG, i / WB, i % WB, d);
        wait_ready();
        chk(busy_cnt - c0 == PC, "R2 busy", busy_cnt - c0, PC);
        chk(done, "R12 done", int'(done), 1);
        @(negedge clk);
        chk(!done, "R12 pulse", int'(done), 0);
      end
      for (int i = 0; i < 3 * WB; i++) rd_chk(i / WB, i % WB, "R2 and");
    end

    // R8 locked block
    issue(C_PROG, 3, 1, 16'h0000);
    chk(prot_err && ready, "R8 prog", {prot_err, ready}, 2'b11);
    rd_chk(3, 1, "R8 data");
    clear_flags("R11 clear");
    issue(C_ERASE, 3, 0, '0);
    chk(prot_err && ready && !seq_err, "R8 erase", {prot_err, ready, seq_err}, 3'b110);
    clear_flags("R11 clear");

    // R3 erase block 1
    c0 = busy_cnt;
    issue(C_ERASE, 1, 0, '0);
    wait_ready();
    chk(busy_cnt - c0 == EC, "R3 busy", busy_cnt - c0, EC);
    chk(done, "R12 erase done", int'(done), 1);
    for (int w = 0; w < WB; w++) model[WB + w] = '1;
    for (int i = 0; i < NW; i++) rd_chk(i / WB, i % WB, "R3 array");

    // R4/R6/R7 erase suspend on block 0
    c0 = busy_cnt;
    issue(C_ERASE, 0, 0, '0);
    @(negedge clk); @(negedge clk);
    issue(C_SUSP, 0, 0, '0);
    chk(ready && suspended && !seq_err, "R4 suspended", {ready, suspended, seq_err}, 3'b110);
    rd_chk(2, 3, "R4 read other");
    issue(C_READ, 0, 1, '0);
    chk(!rd_valid && seq_err, "R6 read same", {rd_valid, seq_err}, 2'b01);
    clear_flags("R11 clear");
    c1 = busy_cnt;
    issue(C_PROG, 2, 1, 16'h00FF);
    model[2*WB+1] = model[2*WB+1] & 16'h00FF;
    chk(suspended && !ready, "R4 nested busy", {suspended, ready}, 2'b10);
    wait_ready();
    c2 = busy_cnt;
    chk(c2 - c1 == PC && done && suspended, "R12 nested done", c2 - c1, PC);
    rd_chk(2, 1, "R4 nested prog");
    issue(C_PROG, 0, 2, 16'h0000);
    chk(seq_err && suspended, "R6 prog same", {seq_err, suspended}, 2'b11);
    clear_flags("R11 clear");
    issue(C_ERASE, 1, 0, '0);
    chk(seq_err, "R9 erase in esusp", int'(seq_err), 1);
    clear_flags("R11 clear");
    issue(C_RES, 0, 0, '0);
    wait_ready();
    c3 = busy_cnt;
    chk((c3 - c0) - (c2 - c1) == EC, "R7 erase total", (c3 - c0) - (c2 - c1), EC);
    chk(!suspended && done, "R7 erase end", {suspended, done}, 2'b01);
    for (int w = 0; w < WB; w++) model[w] = '1;
    for (int w = 0; w < WB; w++) rd_chk(0, w, "R7 erased");

    // R5/R7 program suspend
    c0 = busy_cnt;
    issue(C_PROG, 1, 2, 16'h1234);
    model[WB+2] = model[WB+2] & 16'h1234;
    @(negedge clk);
    issue(C_SUSP, 0, 0, '0);
    chk(ready && suspended, "R5 suspended", {ready, suspended}, 2'b11);
    rd_chk(2, 2, "R5 read other");
    issue(C_PROG, 2, 2, 16'h0000);
    chk(seq_err && suspended, "R5 prog rejected", {seq_err, suspended}, 2'b11);
    clear_flags("R11 clear");
    rd_chk(2, 2, "R5 data kept");
    issue(C_READ, 1, 0, '0);
    chk(!rd_valid && seq_err, "R6 psusp same", {rd_valid, seq_err}, 2'b01);
    clear_flags("R11 clear");
    issue(C_RES, 0, 0, '0);
    wait_ready();
    chk(busy_cnt - c0 == PC, "R7 prog total", busy_cnt - c0, PC);
    rd_chk(1, 2, "R7 prog data");

    // R9 request while busy, suspend/resume while idle
    issue(C_ERASE, 2, 0, '0);
    issue(C_READ, 0, 0, '0);
    chk(seq_err && !rd_valid, "R9 busy read", {seq_err, rd_valid}, 2'b10);
    wait_ready();
    for (int w = 0; w < WB; w++) model[2*WB + w] = '1;
    clear_flags("R11 clear");
    issue(C_SUSP, 0, 0, '0);
    chk(seq_err && !suspended, "R9 idle suspend", {seq_err, suspended}, 2'b10);
    clear_flags("R11 clear");
    issue(C_RES, 0, 0, '0);
    chk(seq_err && ready, "R9 idle resume", {seq_err, ready}, 2'b11);
    clear_flags("R11 clear");

    // R10 suspend colliding with the final busy cycle
    issue(C_PROG, 2, 0, 16'h5A5A);
    model[2*WB] = model[2*WB] & 16'h5A5A;
    repeat (PC - 1) @(negedge clk);
    issue(C_SUSP, 0, 0, '0);
    chk(ready && !suspended && seq_err && done, "R10 collision",
        {ready, suspended, seq_err, done}, 4'b1011);
    rd_chk(2, 0, "R10 data");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule